// File: doc/BRIEF.md
# Masked Lockstep Processing-Element Grid

This block is a grid of small processing elements (PEs), 4x4 by default, that all carry out one command per clock, broadcast by an external controller. A PE has no program and no sequencing of its own: it holds a small register file, a private data memory, a condition flag and an activity bit. The controller supplies the operation, register selectors, one memory address shared by every PE, an immediate and a transfer direction. Every PE whose activity bit is set carries out the command on its own data in the same clock edge. Inactive PEs sit still.

Conditional code runs by masking. Each active PE first computes its condition into its flag. A mask-set command then turns off every PE whose flag is clear and saves the activity it had before. The controller broadcasts the THEN body. A flip command activates exactly those PEs that were active before the conditional and idle during THEN, and the ELSE body follows. An end command restores the saved activity. An OR of all activity bits lets the controller skip an empty body.

Data moves between PEs only through a nearest-neighbour network. In one transfer cycle every PE offers one register value, and every active PE captures the value of the neighbour on one side of the grid. A PE on the edge that has no neighbour on that side captures zero. Neither the controller nor another PE can reach a PE's memory or registers directly.

Top module: `simd_array`

## Requirements
- R1: `cmd_ready` is low while `rst` is high and high from the first clock edge after reset. A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both high, and all active PEs execute it at that edge. `done` is high for exactly the cycle after each accepted command and low otherwise. With `cmd_valid` low, no state changes.
- R2: Register commands write `dst` in every active PE at the accepting edge, with 8-bit wraparound. The opcodes are: 1 = `a+b`, 2 = `a-b`, 3 = `a&b`, 4 = `a|b`, 5 = `imm`, 6 = the PE's own index (row*COLS+col). Here `a` is register `srca` and `b` is register `srcb`. Opcode 0 does nothing.
- R3: An inactive PE does not change its registers, its memory or its flag for any command.
- R4: Opcode 9 loads memory word `cmd_addr` into `dst`, and opcode 10 stores register `srca` into memory word `cmd_addr`. The same address applies in every PE, and each PE has its own memory.
- R5: Opcode 11 (mask set) saves each PE's activity bit. An active PE stays active only if its flag is 1, and an inactive PE stays inactive.
- R6: Opcode 12 (flip) makes active exactly the PEs whose saved bit is 1 and whose current activity bit is 0.
- R7: Opcode 13 (end) restores every PE's activity bit from its saved bit.
- R8: Opcode 14 writes into `dst` of each active PE the register `srca` of a neighbour, or zero if there is no such neighbour. All PEs send, including inactive ones, and every PE sends the value it held before the edge. The `cmd_dir` values are: 0 = data moves north (from row+1), 1 = south (from row-1), 2 = east (from col-1), 3 = west (from col+1).
- R9: `any_active` is 1 exactly when at least one PE activity bit is set.
- R10: Reset makes every PE active with saved bit 1 and flag 0, and clears `done`.
- R11: Opcode 15 makes every PE active and sets every saved bit to 1.
- R12: Opcode 7 sets the flag of each active PE to (register `srca` < `imm`, unsigned). Opcode 8 sets it to (register `srca` == `imm`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 4 | Operation code |
| cmd_dst | input | 2 | Destination register |
| cmd_srca | input | 2 | First source register (also the value sent and stored) |
| cmd_srcb | input | 2 | Second source register |
| cmd_addr | input | 4 | Local memory address, the same in all PEs |
| cmd_imm | input | 8 | Immediate value |
| cmd_dir | input | 2 | Neighbour transfer direction |
| cmd_ready | output | 1 | Commands can be accepted |
| done | output | 1 | Pulses the cycle after an accepted command |
| any_active | output | 1 | OR of all PE activity bits |
| pe_flag | output | 16 | Condition flag of each PE, bit p is PE p |
| pe_active | output | 16 | Activity bit of each PE, bit p is PE p |

## Verification
The hardest collision is a neighbour transfer whose destination register is also its source. In that cycle every PE must send its old value while overwriting the same register, so reading and writing meet on one edge across the whole grid. The bench provokes this with a transfer whose `dst` equals `srca`, issued while part of the grid is masked. The bench also issues mask commands back to back with flag updates. A reference model takes a snapshot of all sent values before it updates any PE, and then compares flags, activity, `any_active` and `done` on every clock. Subtract-and-compare commands make wrong register contents show up in the flags.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_LDI   = 4'd5,
    OP_LID   = 4'd6,
    OP_CMPLT = 4'd7,
    OP_CMPEQ = 4'd8,
    OP_LOAD  = 4'd9,
    OP_STORE = 4'd10,
    OP_SETM  = 4'd11,
    OP_FLIPM = 4'd12,
    OP_ENDIF = 4'd13,
    OP_SHIFT = 4'd14,
    OP_ALLON = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW   = 8,
  parameter int LANE = 0
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] nbr,
  input  logic [DW-1:0] mrd,
  output logic [DW-1:0] wval,
  output logic          wen,
  output logic          cmp_en,
  output logic          cmp_v
);
  localparam logic [DW-1:0] LANE_V = DW'(LANE);

  always_comb begin
    wval   = '0;
    wen    = 1'b0;
    cmp_en = 1'b0;
    cmp_v  = 1'b0;
    case (op)
      OP_ADD:   begin wval = a + b;  wen = 1'b1; end
      OP_SUB:   begin wval = a - b;  wen = 1'b1; end
      OP_AND:   begin wval = a & b;  wen = 1'b1; end
      OP_OR:    begin wval = a | b;  wen = 1'b1; end
      OP_LDI:   begin wval = imm;    wen = 1'b1; end
      OP_LID:   begin wval = LANE_V; wen = 1'b1; end
      OP_LOAD:  begin wval = mrd;    wen = 1'b1; end
      OP_SHIFT: begin wval = nbr;    wen = 1'b1; end
      OP_CMPLT: begin cmp_en = 1'b1; cmp_v = (a < imm);  end
      OP_CMPEQ: begin cmp_en = 1'b1; cmp_v = (a == imm); end
      default:  ;
    endcase
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NREG      = 4,
  parameter int MEM_DEPTH = 16,
  parameter int LANE      = 0,
  localparam int RW = $clog2(NREG),
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec,
  input  op_e           op,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] srca,
  input  logic [RW-1:0] srcb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] nbr_in,
  output logic [DW-1:0] send,
  output logic          flag_q,
  output logic          act_q
);
  logic [DW-1:0] rf  [NREG];
  logic [DW-1:0] mem [MEM_DEPTH];
  logic          save_q;
  logic [DW-1:0] opa, opb, mrd, wval;
  logic          wen, cmp_en, cmp_v;

  assign opa  = rf[srca];
  assign opb  = rf[srcb];
  assign mrd  = mem[addr];
  assign send = opa;

  simd_alu #(.DW(DW), .LANE(LANE)) u_alu (
    .op     (op),
    .a      (opa),
    .b      (opb),
    .imm    (imm),
    .nbr    (nbr_in),
    .mrd    (mrd),
    .wval   (wval),
    .wen    (wen),
    .cmp_en (cmp_en),
    .cmp_v  (cmp_v)
  );

  always_ff @(posedge clk) begin
    if (exec && act_q && wen) rf[dst] <= wval;
  end

  always_ff @(posedge clk) begin
    if (exec && act_q && op == OP_STORE) mem[addr] <= opa;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b1;
      save_q <= 1'b1;
      flag_q <= 1'b0;
    end else if (exec) begin
      case (op)
        OP_SETM: begin
          save_q <= act_q;
          act_q  <= act_q & flag_q;
        end
        OP_FLIPM: act_q <= save_q & ~act_q;
        OP_ENDIF: act_q <= save_q;
        OP_ALLON: begin
          act_q  <= 1'b1;
          save_q <= 1'b1;
        end
        default: if (act_q && cmp_en) flag_q <= cmp_v;
      endcase
    end
  end

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (exec && !act_q) |=> $stable(flag_q)) else $error("idle PE changed flag"); // R3
  AST_SET_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_SETM) |=> (!act_q || $past(act_q))) else $error("mask set woke a PE"); // R5
  AST_ELSE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_FLIPM) |=> !(act_q && $past(act_q))) else $error("PE active in both bodies"); // R6
endmodule

// File: rtl/simd_xfer.sv
module simd_xfer
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int NPE = ROWS * COLS
) (
  input  dir_e              dir,
  input  logic [NPE*DW-1:0] send,
  output logic [NPE*DW-1:0] recv
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P     = r * COLS + c;
      localparam bit HAS_N = (r + 1 < ROWS);
      localparam bit HAS_S = (r > 0);
      localparam bit HAS_E = (c > 0);
      localparam bit HAS_W = (c + 1 < COLS);
      localparam int IN    = HAS_N ? P + COLS : P;
      localparam int IS    = HAS_S ? P - COLS : P;
      localparam int IE    = HAS_E ? P - 1 : P;
      localparam int IW    = HAS_W ? P + 1 : P;
      logic [DW-1:0] from_n, from_s, from_e, from_w;
      assign from_n = HAS_N ? send[IN*DW +: DW] : '0;
      assign from_s = HAS_S ? send[IS*DW +: DW] : '0;
      assign from_e = HAS_E ? send[IE*DW +: DW] : '0;
      assign from_w = HAS_W ? send[IW*DW +: DW] : '0;
      assign recv[P*DW +: DW] = (dir == DIR_N) ? from_n :
                                (dir == DIR_S) ? from_s :
                                (dir == DIR_E) ? from_e : from_w;
    end
  end
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int DW        = 8,
  parameter int NREG      = 4,
  parameter int MEM_DEPTH = 16,
  localparam int NPE = ROWS * COLS,
  localparam int RW  = $clog2(NREG),
  localparam int AW  = $clog2(MEM_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [RW-1:0]  cmd_dst,
  input  logic [RW-1:0]  cmd_srca,
  input  logic [RW-1:0]  cmd_srcb,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_imm,
  input  logic [1:0]     cmd_dir,
  output logic           cmd_ready,
  output logic           done,
  output logic           any_active,
  output logic [NPE-1:0] pe_flag,
  output logic [NPE-1:0] pe_active
);
  op_e               op;
  dir_e              dir;
  logic              ready_q, done_q, exec;
  logic [NPE*DW-1:0] send_bus, recv_bus;

  assign op   = op_e'(cmd_op);
  assign dir  = dir_e'(cmd_dir);
  assign exec = cmd_valid & ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= exec;
    end
  end

  assign cmd_ready  = ready_q;
  assign done       = done_q;
  assign any_active = |pe_active;

  simd_xfer #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_xfer (
    .dir  (dir),
    .send (send_bus),
    .recv (recv_bus)
  );

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    simd_pe #(.DW(DW), .NREG(NREG), .MEM_DEPTH(MEM_DEPTH), .LANE(p)) u_pe (
      .clk    (clk),
      .rst    (rst),
      .exec   (exec),
      .op     (op),
      .dst    (cmd_dst),
      .srca   (cmd_srca),
      .srcb   (cmd_srcb),
      .addr   (cmd_addr),
      .imm    (cmd_imm),
      .nbr_in (recv_bus[p*DW +: DW]),
      .send   (send_bus[p*DW +: DW]),
      .flag_q (pe_flag[p]),
      .act_q  (pe_active[p])
    );
  end

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready)) else $error("done without command"); // R1
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cmd_ready) else $error("ready dropped outside reset"); // R1
endmodule

// File: tb/sim_simd_array.sv
module sim_simd_array;
  localparam int NP = 16;
  localparam int OP_ADD = 1, OP_SUB = 2, OP_AND = 3, OP_OR = 4, OP_LDI = 5, OP_LID = 6;
  localparam int OP_CLT = 7, OP_CEQ = 8, OP_LD = 9, OP_ST = 10, OP_SETM = 11;
  localparam int OP_FLIP = 12, OP_ENDIF = 13, OP_SHF = 14, OP_ALL = 15;

  logic clk = 1'b0, rst = 1'b1, valid = 1'b0;
  logic [3:0] op = '0, addr = '0;
  logic [1:0] dst = '0, sa = '0, sb = '0, dir = '0;
  logic [7:0] imm = '0;
  logic ready, done, any;
  logic [NP-1:0] flag, act;

  always #5 clk = ~clk;

  simd_array u0 (
    .clk(clk), .rst(rst), .cmd_valid(valid), .cmd_op(op), .cmd_dst(dst),
    .cmd_srca(sa), .cmd_srcb(sb), .cmd_addr(addr), .cmd_imm(imm), .cmd_dir(dir),
    .cmd_ready(ready), .done(done), .any_active(any), .pe_flag(flag), .pe_active(act)
  );

  // reference model
  logic [7:0] m_rf [NP][4];
  logic [7:0] m_mem [NP][16];
  bit m_act [NP], m_save [NP], m_flag [NP];
  bit m_ready = 0, m_done = 0;
  string cur_tag = "R10", last_tag = "R10";
  int nchk = 0, nfail = 0;
  bit run = 0, finished = 0;

  initial begin
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < 4; i++) m_rf[p][i] = '0;
      for (int i = 0; i < 16; i++) m_mem[p][i] = '0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin m_act[p] = 1; m_save[p] = 1; m_flag[p] = 0; end
      m_ready = 0; m_done = 0; last_tag = "R10";
    end else begin
      bit acc;
      logic [7:0] sendv [NP];
      acc = valid && m_ready;
      m_done = acc;
      m_ready = 1;
      last_tag = acc ? cur_tag : "R1";
      if (acc) begin
        for (int p = 0; p < NP; p++) sendv[p] = m_rf[p][sa];
        for (int p = 0; p < NP; p++) begin
          int r, c;
          logic [7:0] av, bv, nb;
          r = p / 4; c = p % 4;
          av = m_rf[p][sa]; bv = m_rf[p][sb];
          nb = 8'h00;
          case (dir)
            2'd0: if (r < 3) nb = sendv[p + 4];
            2'd1: if (r > 0) nb = sendv[p - 4];
            2'd2: if (c > 0) nb = sendv[p - 1];
            default: if (c < 3) nb = sendv[p + 1];
          endcase
          if (m_act[p]) begin
            case (int'(op))
              OP_ADD: m_rf[p][dst] = av + bv;
              OP_SUB: m_rf[p][dst] = av - bv;
              OP_AND: m_rf[p][dst] = av & bv;
              OP_OR:  m_rf[p][dst] = av | bv;
              OP_LDI: m_rf[p][dst] = imm;
              OP_LID: m_rf[p][dst] = 8'(p);
              OP_CLT: m_flag[p] = (av < imm);
              OP_CEQ: m_flag[p] = (av == imm);
              OP_LD:  m_rf[p][dst] = m_mem[p][addr];
              OP_ST:  m_mem[p][addr] = av;
              OP_SHF: m_rf[p][dst] = nb;
              default: ;
            endcase
          end
          case (int'(op))
            OP_SETM: begin m_save[p] = m_act[p]; m_act[p] = m_act[p] && m_flag[p]; end
            OP_FLIP: m_act[p] = m_save[p] && !m_act[p];
            OP_ENDIF: m_act[p] = m_save[p];
            OP_ALL: begin m_act[p] = 1; m_save[p] = 1; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      logic [NP-1:0] ef, ea;
      bit eany;
      eany = 0;
      for (int p = 0; p < NP; p++) begin ef[p] = m_flag[p]; ea[p] = m_act[p]; eany |= m_act[p]; end
      nchk++;
      if (flag !== ef || act !== ea || any !== eany || done !== m_done || ready !== m_ready) begin
        nfail++;
        $display("FAIL %s flag=%h/%h act=%h/%h any=%b/%b done=%b/%b ready=%b/%b (got/exp)",
                 last_tag, flag, ef, act, ea, any, eany, done, m_done, ready, m_ready);
      end
    end
  end

  task automatic cmd(input int o, input int d, input int a, input int b,
                     input int ad, input int im, input int dr, input string t);
    @(negedge clk);
    valid = 1; op = 4'(o); dst = 2'(d); sa = 2'(a); sb = 2'(b);
    addr = 4'(ad); imm = 8'(im); dir = 2'(dr); cur_tag = t;
  endtask

  task automatic idle(input int n);
    @(negedge clk); valid = 0; op = 4'(OP_ALL); cur_tag = "R1";
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    finished = 1;
    $finish;
  endtask

  initial begin
    @(posedge clk); #1 run = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;                          // R10 checked during reset
    idle(2);                                           // R1 ready rises, done stays low
    // initialise registers and memories
    for (int i = 0; i < 4; i++) cmd(OP_LDI, i, 0, 0, 0, 0, 0, "R2");
    cmd(OP_ST, 0, 0, 0, 2, 0, 0, "R4");
    // R2 arithmetic
    cmd(OP_LID, 0, 0, 0, 0, 0, 0, "R2");
    cmd(OP_LDI, 1, 0, 0, 0, 3, 0, "R2");
    cmd(OP_ADD, 2, 0, 1, 0, 0, 0, "R2");
    cmd(OP_CEQ, 0, 2, 0, 0, 5, 0, "R12");
    cmd(OP_SUB, 3, 1, 0, 0, 0, 0, "R2");
    cmd(OP_CLT, 0, 3, 0, 0, 2, 0, "R12");
    cmd(OP_AND, 2, 0, 1, 0, 0, 0, "R2");
    cmd(OP_CEQ, 0, 2, 0, 0, 1, 0, "R2");
    cmd(OP_OR, 2, 0, 1, 0, 0, 0, "R2");
    cmd(OP_CEQ, 0, 2, 0, 0, 7, 0, "R2");
    idle(1);
    // R4 local memory
    cmd(OP_ST, 0, 0, 0, 5, 0, 0, "R4");
    cmd(OP_LDI, 0, 0, 0, 0, 0, 0, "R4");
    cmd(OP_LD, 0, 0, 0, 5, 0, 0, "R4");
    cmd(OP_CEQ, 0, 0, 0, 0, 7, 0, "R4");
    cmd(OP_CLT, 0, 0, 0, 0, 8, 0, "R12");
    // if-then-else
    cmd(OP_CLT, 0, 0, 0, 0, 6, 0, "R12");
    cmd(OP_SETM, 0, 0, 0, 0, 0, 0, "R5");
    cmd(OP_LDI, 1, 0, 0, 0, 8'hAA, 0, "R3");
    cmd(OP_ST, 0, 1, 0, 2, 0, 0, "R3");
    cmd(OP_CEQ, 0, 0, 0, 0, 9, 0, "R3");
    cmd(OP_FLIP, 0, 0, 0, 0, 0, 0, "R6");
    cmd(OP_LDI, 1, 0, 0, 0, 8'h55, 0, "R6");
    cmd(OP_ENDIF, 0, 0, 0, 0, 0, 0, "R7");
    cmd(OP_CEQ, 0, 1, 0, 0, 8'hAA, 0, "R7");
    cmd(OP_LD, 3, 0, 0, 2, 0, 0, "R3");
    cmd(OP_CEQ, 0, 3, 0, 0, 8'hAA, 0, "R3");
    cmd(OP_CEQ, 0, 1, 0, 0, 8'h55, 0, "R6");
    // flip bounded by the pre-conditional set
    cmd(OP_CLT, 0, 0, 0, 0, 12, 0, "R12");
    cmd(OP_SETM, 0, 0, 0, 0, 0, 0, "R5");
    cmd(OP_CLT, 0, 0, 0, 0, 4, 0, "R12");
    cmd(OP_SETM, 0, 0, 0, 0, 0, 0, "R5");
    cmd(OP_FLIP, 0, 0, 0, 0, 0, 0, "R6");
    cmd(OP_ENDIF, 0, 0, 0, 0, 0, 0, "R7");
    cmd(OP_ALL, 0, 0, 0, 0, 0, 0, "R11");
    // empty body
    cmd(OP_CLT, 0, 0, 0, 0, 0, 0, "R9");
    cmd(OP_SETM, 0, 0, 0, 0, 0, 0, "R9");
    cmd(OP_LDI, 0, 0, 0, 0, 8'hEE, 0, "R3");
    cmd(OP_CEQ, 0, 0, 0, 0, 8'hEE, 0, "R3");
    cmd(OP_FLIP, 0, 0, 0, 0, 0, 0, "R9");
    cmd(OP_CEQ, 0, 0, 0, 0, 3, 0, "R12");
    cmd(OP_ENDIF, 0, 0, 0, 0, 0, 0, "R7");
    // neighbour transfers, every direction
    for (int d = 0; d < 4; d++) begin
      cmd(OP_LID, 0, 0, 0, 0, 0, 0, "R8");
      cmd(OP_SHF, 2, 0, 0, 0, 0, d, "R8");
      cmd(OP_SUB, 3, 2, 0, 0, 0, 0, "R8");
      cmd(OP_CEQ, 0, 3, 0, 0, (d == 0) ? 4 : (d == 1) ? 252 : (d == 2) ? 255 : 1, 0, "R8");
      cmd(OP_CEQ, 0, 2, 0, 0, 0, 0, "R8");
    end
    // transfer onto its own source, with part of the grid masked
    cmd(OP_LID, 0, 0, 0, 0, 0, 0, "R8");
    cmd(OP_CLT, 0, 0, 0, 0, 10, 0, "R12");
    cmd(OP_SETM, 0, 0, 0, 0, 0, 0, "R5");
    cmd(OP_SHF, 0, 0, 0, 0, 0, 2, "R8");
    cmd(OP_ALL, 0, 0, 0, 0, 0, 0, "R11");
    for (int v = 0; v < 16; v++) cmd(OP_CEQ, 0, 0, 0, 0, v, 0, "R8");
    idle(3);
    finish_run();
  end

  initial begin
    #200000;
    if (!finished) begin
      nfail++;
      $display("FAIL R1 watchdog expired got=hung exp=finished");
      finish_run();
    end
  end
endmodule